// File: doc/BRIEF.md
# Maskable Interrupt Controller with Selectable Clear

This block gathers up to 32 interrupt lines next to a CPU core and turns them into one interrupt request and the index of the line to service first. Each line has an enable bit in a mask register and a pending bit in a status register, both at the line's own bit position. Software reaches both registers through a small special-register port. A select bit picks the register. A write enable commits the 32-bit write data. Read data is valid in the same cycle.

A build-time mode parameter fixes how pending bits are captured and cleared. Level mode (0) shows the synchronized inputs directly, and status writes do nothing. Edge mode (1) latches rising edges, and a written 1 clears a bit. Latched-level mode (2) latches high levels, and a written 0 clears a bit. The request to the CPU is raised when any line is both pending and enabled. The controller also reports the lowest pending enabled index, so software services lines from index 0 upward.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the mask and status registers both read as zero, and `cpu_irq` and `irq_any` are low.
- R2: A write with `reg_we`=1 and `reg_sel`=0 loads the mask register with `reg_wdata`. Mask bit 1 enables its line and bit 0 disables it. Writing all zeros disables every line at once.
- R3: `reg_rdata` shows the mask register when `reg_sel`=0 and the status register when `reg_sel`=1, in the same cycle as the select, so single bits can be read, modified and written back.
- R4: With MODE=0, status bit i equals input line i after a two-flop synchronizer, so it changes two clock edges after the input. Writes to the status register have no effect.
- R5: With MODE=1, a rising edge on line i sets status bit i on the third clock edge after the input rises. The bit stays set after the input falls.
- R6: With MODE=1, a status write clears every bit where `reg_wdata` is 1 and leaves every bit where it is 0.
- R7: With MODE=2, a synchronized high level sets status bit i and the bit stays set after the input drops. A status write clears every bit where `reg_wdata` is 0 and leaves every bit where it is 1.
- R8: In MODE=1 and MODE=2, if a line's capture condition is true in the same cycle as a write that would clear its bit, the bit ends up set.
- R9: `cpu_irq` is the OR over all lines of status AND mask. Masked lines still record status but do not raise `cpu_irq`.
- R10: `irq_any` is high when any line is both pending and enabled. `irq_idx` is then the lowest such bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Asynchronous interrupt lines |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Write enable for the selected register |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data of the selected register |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| irq_idx | output | $clog2(NLINES) | Lowest pending enabled line |
| irq_any | output | 1 | Some enabled line is pending |

## Verification
The bench builds three copies of the controller with NLINES=32, one for each MODE value (0, 1, 2). All three share the same stimulus, so the same status write can be checked side by side. One write is ignored in level mode, clears ones in edge mode, and clears zeros in latched mode. Driving an edge or a high level in the exact cycle of a clearing write reaches the set-wins case in both latching modes. Full-width mask patterns reach line 31 and the lowest-index encoder across the whole vector.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NLINES = 32,
  parameter int MODE   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NLINES-1:0]          irq_in,
  input  logic                       reg_sel,
  input  logic                       reg_we,
  input  logic [NLINES-1:0]          reg_wdata,
  output logic [NLINES-1:0]          reg_rdata,
  output logic                       cpu_irq,
  output logic [$clog2(NLINES)-1:0]  irq_idx,
  output logic                       irq_any
);
  localparam int IDXW = $clog2(NLINES);

  logic [NLINES-1:0] sync1, sync2, prev, mask_q, status, pending;
  logic              st_wr;

  assign st_wr = reg_we && reg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev   <= '0;
      mask_q <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      if (reg_we && !reg_sel) mask_q <= reg_wdata;
    end
  end

  generate
    if (MODE == 0) begin : g_level
      assign status = sync2;
    end else if (MODE == 1) begin : g_edge
      logic [NLINES-1:0] st_q;
      always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~(st_wr ? reg_wdata : '0)) | (sync2 & ~prev);
      end
      assign status = st_q;
    end else begin : g_latch
      logic [NLINES-1:0] st_q;
      always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & (st_wr ? reg_wdata : '1)) | sync2;
      end
      assign status = st_q;
    end
  endgenerate

  assign pending   = status & mask_q;
  assign cpu_irq   = |pending;
  assign irq_any   = cpu_irq;
  assign reg_rdata = reg_sel ? status : mask_q;

  always_comb begin
    irq_idx = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (pending[i]) irq_idx = IDXW'(i);
  end

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (mask_q == $past(reg_wdata)));

  // R10
  idx_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> pending[irq_idx]);

  // R10
  idx_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((pending & ((NLINES'(1) << irq_idx) - NLINES'(1))) == '0));

  // R9
  req_vs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !cpu_irq);

  generate
    if (MODE != 0) begin : g_hold_chk
      // R5 R7
      status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_sel) |=> ((status & $past(status)) == $past(status)));
    end else begin : g_lvl_chk
      // R4
      level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status == $past(sync1)));
    end
  endgenerate
endmodule

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] rd [3];
  logic req [3];
  logic any [3];
  logic [4:0] idx [3];

  always #10 clk = ~clk;

  irq_ctrl #(.NLINES(N), .MODE(0)) u0 (.clk, .rst_n, .irq_in, .reg_sel, .reg_we, .reg_wdata,
    .reg_rdata(rd[0]), .cpu_irq(req[0]), .irq_idx(idx[0]), .irq_any(any[0]));
  irq_ctrl #(.NLINES(N), .MODE(1)) u1 (.clk, .rst_n, .irq_in, .reg_sel, .reg_we, .reg_wdata,
    .reg_rdata(rd[1]), .cpu_irq(req[1]), .irq_idx(idx[1]), .irq_any(any[1]));
  irq_ctrl #(.NLINES(N), .MODE(2)) u2 (.clk, .rst_n, .irq_in, .reg_sel, .reg_we, .reg_wdata,
    .reg_rdata(rd[2]), .cpu_irq(req[2]), .irq_idx(idx[2]), .irq_any(any[2]));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference: input history and per-mode pending sets
  bit hist [3][N];
  bit m_mask [N];
  bit m_st [3][N];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int d = 0; d < 3; d++) hist[d][i] = 0;
        m_mask[i] = 0;
        for (int k = 0; k < 3; k++) m_st[k][i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit seen, rise, clr_e, clr_l;
        seen  = hist[1][i];
        rise  = hist[1][i] && !hist[2][i];
        clr_e = reg_we && reg_sel && reg_wdata[i];
        clr_l = reg_we && reg_sel && !reg_wdata[i];
        if (rise) m_st[1][i] = 1; else if (clr_e) m_st[1][i] = 0;
        if (seen) m_st[2][i] = 1; else if (clr_l) m_st[2][i] = 0;
        if (reg_we && !reg_sel) m_mask[i] = reg_wdata[i];
        hist[2][i] = hist[1][i];
        hist[1][i] = hist[0][i];
        hist[0][i] = irq_in[i];
        m_st[0][i] = hist[1][i];
      end
    end
  end

  task automatic fail_line(string req_tag, int k, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s inst%0d actual %h expected %h", req_tag, k, act, exp);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      for (int k = 0; k < 3; k++) begin
        logic [N-1:0] st, mk, pend;
        int lo;
        for (int i = 0; i < N; i++) begin st[i] = m_st[k][i]; mk[i] = m_mask[i]; end
        pend = st & mk;
        lo = 0;
        for (int i = N - 1; i >= 0; i--) if (pend[i]) lo = i;
        checks++; // R3
        if (rd[k] !== (reg_sel ? st : mk)) fail_line("R3", k, rd[k], reg_sel ? st : mk);
        checks++; // R9
        if (req[k] !== (pend != 0)) fail_line("R9", k, 32'(req[k]), 32'(pend != 0));
        checks++; // R10
        if (any[k] !== (pend != 0) || (pend != 0 && idx[k] !== 5'(lo)))
          fail_line("R10", k, {26'(any[k]), idx[k]}, {26'(pend != 0), 5'(lo)});
      end
    end
  end

  task automatic expect_val(string req_tag, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) fail_line(req_tag, k, act, exp);
  endtask

  task automatic wr(input logic sel, input logic [N-1:0] d);
    @(negedge clk); reg_sel = sel; reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic sel, string req_tag, logic [31:0] e0, logic [31:0] e1, logic [31:0] e2);
    @(negedge clk); reg_sel = sel; #2;
    expect_val(req_tag, 0, rd[0], e0);
    expect_val(req_tag, 1, rd[1], e1);
    expect_val(req_tag, 2, rd[2], e2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd_chk(0, "R1", 0, 0, 0);
    rd_chk(1, "R1", 0, 0, 0);
    for (int k = 0; k < 3; k++) expect_val("R1", k, 32'(req[k]), 0);

    // R2
    wr(0, '1);
    rd_chk(0, "R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    irq_in = 32'h0000_0014;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) expect_val("R10", k, 32'(idx[k]), 2);
    irq_in = '0;
    repeat (4) @(negedge clk);
    // R4 R5 R7
    rd_chk(1, "R5", 0, 32'h14, 32'h14);
    expect_val("R4", 0, 32'(req[0]), 0);

    // R4 R6 R7 clear polarity
    wr(1, 32'h0000_0004);
    rd_chk(1, "R6", 0, 32'h10, 32'h04);
    wr(1, '1);
    rd_chk(1, "R7", 0, 0, 32'h04);
    wr(1, '0);
    rd_chk(1, "R7", 0, 0, 0);

    // R8 set wins over a clearing write in the capture cycle
    @(negedge clk); irq_in = 32'h80;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_sel = 1; reg_we = 1; reg_wdata = 32'h80;
    @(negedge clk); reg_wdata = 32'h0;
    @(negedge clk); reg_we = 0;
    rd_chk(1, "R8", 32'h80, 32'h80, 32'h80);

    // R9 masked lines record but stay quiet
    wr(0, 32'h0000_0100);
    irq_in = 32'h88;
    repeat (4) @(negedge clk);
    rd_chk(1, "R9", 32'h88, 32'h88, 32'h88);
    for (int k = 0; k < 3; k++) expect_val("R9", k, 32'(req[k]), 0);
    wr(0, 32'h8000_0000);
    irq_in = 32'h8000_0000;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 3; k++) expect_val("R10", k, 32'(idx[k]), 31);
    wr(0, '0); // R2 disable all
    for (int k = 0; k < 3; k++) expect_val("R2", k, 32'(req[k]), 0);

    // random traffic compared each clock
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) irq_in = irq_in ^ (32'(1) << $urandom_range(0, 31));
      reg_sel   = 1'($urandom_range(0, 1));
      reg_we    = ($urandom_range(0, 5) == 0);
      reg_wdata = $urandom;
    end
    @(negedge clk); reg_we = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule